// File: doc/BRIEF.md
# Boot Mode Capture Status Word

This block records how a processor core was asked to boot. It watches the external boot-mode pins and a secure-boot strap. It stores their values once, at the moment the chip reset is released. The stored values are then held in a read-only 32-bit status word, together with the core number, until the next reset. Pin activity after the capture, such as a debug probe releasing a pin it was holding low, has no effect on the word.

Next to the word, the block drives the effective boot mode that boot firmware acts on. The two low mode bits select one of four boot sources. On every core except core 0, a request to boot from SPI flash becomes a request to boot from the inter-core link. While reset is held the word reads as zero, and the effective mode is flagged as not valid.

The asynchronous active-low reset is released through a two-flop stage. The pins and the strap pass through a two-stage synchroniser before they are captured. The core number is fixed per instance by a parameter.

Top module: `bootmode_capture`

## Requirements
- R1: While `rst_n` is low, `status_word` is 0, `eff_valid` is 0 and `eff_mode` is 0.
- R2: After `rst_n` rises between two clock edges, `eff_valid` stays 0 through the first two rising edges and becomes 1 on the third. The captured values are those present on `mode_pins` and `secure_strap` at the first of those edges.
- R3: After the capture, changes on `mode_pins` leave `status_word` and `eff_mode` unchanged until reset is asserted again.
- R4: Once `eff_valid` is 1, `status_word[7:0]` equals the captured `mode_pins`. Bits 1..0 are the boot mode.
- R5: Once `eff_valid` is 1, `status_word[23:16]` equals the `CORE_ID` parameter.
- R6: Once `eff_valid` is 1, `status_word[8]` equals the captured `secure_strap`. Later changes of the strap have no effect.
- R7: `status_word[31:24]` and `status_word[15:9]` always read 0.
- R8: Mode encodings are 0 = RAM, 1 = link, 2 = SPI and 3 = JTAG (wait for the debugger). On core 0, `eff_mode` equals `status_word[1:0]`. For example, pins 0xFE on core 0 give the word 0x000000FE and an effective mode of 2.
- R9: When `CORE_ID` is not 0, a captured mode of 2 gives an `eff_mode` of 1. The modes 0, 1 and 3 pass through unchanged.
- R10: Asserting `rst_n` again clears the word. The following release captures the pins afresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| mode_pins | input | 8 | External boot-mode pins |
| secure_strap | input | 1 | Secure-boot strap |
| status_word | output | 32 | Captured status word |
| eff_mode | output | 2 | Effective boot mode used by firmware |
| eff_valid | output | 1 | High once the capture has happened |

## Verification
On every cycle, the embedded assertions check four things. The word is zero under reset. It holds steady once valid. The effective mode agrees with the stored low bits, with the SPI-to-link remap applied on non-zero cores. Valid can only rise two edges after reset has been seen high. The cycle on which the pins are actually sampled can only be shown by the bench's scenarios. So can the ignoring of later pin and strap changes, and recapture after a second reset. The bench drives distinct pin values around the release and compares the word against values it computes itself, on core 0 and on a non-zero core.

// File: rtl/bootmode_capture.sv
module bootmode_capture #(
  parameter int CORE_ID = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  mode_pins,
  input  logic        secure_strap,
  output logic [31:0] status_word,
  output logic [1:0]  eff_mode,
  output logic        eff_valid
);
  localparam logic [7:0] CORE_NUM = CORE_ID[7:0];
  localparam logic [1:0] MODE_LINK = 2'd1;
  localparam logic [1:0] MODE_SPI  = 2'd2;

  logic [1:0] rel_q;
  logic       run_n;
  logic [8:0] sync0_q, sync1_q;
  logic [8:0] held_q;
  logic       held_vld_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rel_q <= 2'b00;
    else        rel_q <= {rel_q[0], 1'b1};

  assign run_n = rel_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync0_q <= '0;
      sync1_q <= '0;
    end else begin
      sync0_q <= {secure_strap, mode_pins};
      sync1_q <= sync0_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      held_q     <= '0;
      held_vld_q <= 1'b0;
    end else if (run_n && !held_vld_q) begin
      held_q     <= sync1_q;
      held_vld_q <= 1'b1;
    end

  assign status_word = held_vld_q ? {8'h00, CORE_NUM, 7'h00, held_q[8], held_q[7:0]} : 32'h0;
  assign eff_valid   = held_vld_q;
  assign eff_mode    = !held_vld_q ? 2'd0 :
                       (CORE_NUM != 8'd0 && held_q[1:0] == MODE_SPI) ? MODE_LINK : held_q[1:0];

  AST_ZERO_IN_RESET: assert property (@(posedge clk) !rst_n |-> (status_word == 32'h0 && !eff_valid)) else $error("reset state"); // R1
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) $rose(eff_valid) |-> ($past(rst_n, 1) && $past(rst_n, 2))) else $error("latency"); // R2
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n) eff_valid |=> (eff_valid && $stable(status_word) && $stable(eff_mode))) else $error("word changed"); // R3
  AST_SPI_REMAP: assert property (@(posedge clk) disable iff (!rst_n) (eff_valid && CORE_NUM != 8'd0 && status_word[1:0] == 2'd2) |-> eff_mode == 2'd1) else $error("remap"); // R9
  AST_MODE_PASS: assert property (@(posedge clk) disable iff (!rst_n) (eff_valid && (CORE_NUM == 8'd0 || status_word[1:0] != 2'd2)) |-> eff_mode == status_word[1:0]) else $error("pass"); // R8
  AST_CORE_FIELD: assert property (@(posedge clk) disable iff (!rst_n) eff_valid |-> status_word[23:16] == CORE_NUM) else $error("core"); // R5
endmodule

// File: tb/bootmode_capture_tb.sv
module bootmode_capture_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] pins = 8'hFF;
  logic sec = 1'b0;
  logic [31:0] w0, w2;
  logic [1:0] m0, m2;
  logic v0, v2;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bootmode_capture #(.CORE_ID(0)) dut_i (.clk(clk), .rst_n(rst_n), .mode_pins(pins),
    .secure_strap(sec), .status_word(w0), .eff_mode(m0), .eff_valid(v0));
  bootmode_capture #(.CORE_ID(2)) dut_c2_i (.clk(clk), .rst_n(rst_n), .mode_pins(pins),
    .secure_strap(sec), .status_word(w2), .eff_mode(m2), .eff_valid(v2));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(logic [7:0] core, logic [7:0] p, logic s);
    return {8'h00, core, 7'h00, s, p};
  endfunction

  function automatic logic [1:0] eff_of(logic [7:0] core, logic [7:0] p);
    return (core != 0 && p[1:0] == 2'd2) ? 2'd1 : p[1:0];
  endfunction

  task automatic enter_reset(logic [7:0] p, logic s);
    @(negedge clk);
    rst_n = 1'b0; pins = p; sec = s;
    repeat (3) @(negedge clk);
    chk("R1 word0", w0, 0); chk("R1 valid0", {31'b0, v0}, 0);
    chk("R1 mode0", {30'b0, m0}, 0); chk("R10 word2", w2, 0);
  endtask

  task automatic release_and_capture(logic [7:0] p, logic s);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 no valid after 1 edge", {31'b0, v0}, 0);
    @(negedge clk);
    chk("R2 no valid after 2 edges", {31'b0, v0}, 0);
    pins = ~p; sec = ~s;
    @(negedge clk);
    chk("R2 valid after 3 edges", {31'b0, v0}, 1);
    chk("R4 R5 R6 word core0", w0, word_of(8'd0, p, s));
    chk("R5 word core2", w2, word_of(8'd2, p, s));
    chk("R7 zero fields", w0 & 32'hFF00FE00, 0);
    chk("R8 eff core0", {30'b0, m0}, {30'b0, eff_of(8'd0, p)});
    chk("R9 eff core2", {30'b0, m2}, {30'b0, eff_of(8'd2, p)});
  endtask

  task automatic scen_capture(logic [7:0] p, logic s);
    enter_reset(p, s);
    release_and_capture(p, s);
  endtask

  task automatic scen_ignore_later(logic [7:0] p, logic s);
    enter_reset(p, s);
    release_and_capture(p, s);
    for (int i = 0; i < 6; i++) begin
      pins = 8'(i * 37 + 5); sec = i[0];
      @(negedge clk);
    end
    chk("R3 word after pin changes", w0, word_of(8'd0, p, s));
    chk("R6 strap ignored", {31'b0, w2[8]}, {31'b0, s});
    chk("R3 eff after pin changes", {30'b0, m2}, {30'b0, eff_of(8'd2, p)});
  endtask

  task automatic scen_late_pins();
    enter_reset(8'hFF, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    pins = 8'hFC;
    repeat (3) @(negedge clk);
    chk("R2 pins at first edge captured", w0, word_of(8'd0, 8'hFF, 1'b0));
  endtask

  initial begin
    scen_capture(8'hFE, 1'b0);
    chk("R8 example word", w0, 32'h000000FE);
    chk("R8 example eff", {30'b0, m0}, 2);
    scen_capture(8'hFC, 1'b1);
    scen_capture(8'hFD, 1'b0);
    scen_capture(8'hFF, 1'b1);
    scen_capture(8'h5A, 1'b0);
    scen_ignore_later(8'hFE, 1'b1);
    scen_ignore_later(8'h03, 1'b0);
    scen_late_pins();
    scen_capture(8'hA1, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule